// File: doc/BRIEF.md
# Descriptor Queue Manager

This block keeps a set of hardware FIFO queues whose entries are packet-descriptor pointers for a DMA engine. A master pushes a descriptor by writing its pointer to a queue's port register. It pops the oldest pointer by reading that same register. Descriptors are 32-byte aligned, so the five low bits of a pointer are not address bits. They carry a size hint that the block stores and hands back unchanged on pop.

Queue storage is a single linked list over one next-pointer memory. That memory is indexed by the descriptor's position inside one configured descriptor region, and each queue keeps its own head, tail and count. Non-empty status is packed 32 queues to a register for polling. A subset of queues, chosen at build time, are completion queues. When one of them goes from empty to non-empty, a sticky flag is raised, and it drives the interrupt while the interrupt is enabled.

Top module: `desc_queue_mgr`

## Requirements
- R1: After reset every queue is empty, every pending register reads 0, the status register (0x28) reads 0 and `irq` is low.
- R2: A write to 0x200C + 16*n (n < NQ) holding an in-region pointer appends that pointer to queue n. A read of the same address returns the oldest entry with its low 5 bits exactly as written, and removes it (first in, first out). The read value appears on `rdata` in the cycle after the request.
- R3: A read of an empty queue's port returns 0 and changes no queue.
- R4: Pending register i at 0x90 + 4*i has bit b set exactly when queue 32*i+b holds at least one entry. Bits for queues at or above NQ read 0.
- R5: The region base is written at 0x1000. The control word at 0x1004 holds the first descriptor index in bits [31:16], log2(size)-5 in bits [11:8] and log2(count)-5 in bits [4:0]. A pointer p (low 5 bits cleared) maps to index first + (p - base) / size.
- R6: A pushed pointer is rejected when it lies below the base, when it is not a multiple of the descriptor size from the base, when it lies at or past count descriptors, or when its index is at or above ND. A rejected pointer is not queued and sets status bit 0.
- R7: A push that makes an empty completion queue non-empty sets status bit 2. A push to a non-completion queue, or to a completion queue that already holds an entry, does not set it. `irq` equals status bit 2 AND enable bit 2.
- R8: Writing 1s to 0x28 clears those status bits. Writing 1 to bit 2 of 0x2C sets the enable bit, and writing 1 to bit 2 of 0x30 clears it. The enable bit reads back at 0x2C bit 2.
- R9: The link-memory base (0x80) and size (0x84) registers read back what was written.
- R10: Queues are independent: interleaved pushes to two queues pop back in per-queue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Register access request, one per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with 40 queues, 32 descriptors and queues 32 to 39 as completion queues. This gives two pending registers, the second only partly populated, so the bits above NQ are exposed. It also makes a sweep over every queue cheap: each queue is pushed once, both pending words are checked and the entry is popped. Because the link memory has only 32 entries, the index-bound rejection (first index 30) and the count-bound rejection are both reachable with small addresses. Re-programming the size field to 64 bytes exposes the alignment rejection.

// File: rtl/desc_queue_mgr.sv
module desc_queue_mgr #(
  parameter int NQ = 64,
  parameter int ND = 128,
  parameter int AW = 16,
  parameter logic [NQ-1:0] CQ_MASK = {NQ{1'b1}} << (NQ/2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int QW  = $clog2(NQ);
  localparam int IW  = $clog2(ND);
  localparam int CW  = IW + 1;
  localparam int NPW = (NQ + 31) / 32;

  logic [IW-1:0] head [NQ];
  logic [IW-1:0] tail [NQ];
  logic [CW-1:0] cnt  [NQ];
  logic [IW-1:0] nxt  [ND];
  logic [31:0]   val  [ND];

  logic [31:0] rbase, lbase, lsize;
  logic [15:0] rfirst;
  logic [3:0]  rsz;
  logic [4:0]  rcnt;
  logic        st_err, st_cmp, en_cmp;

  logic [AW-1:0] qoff, poff;
  logic [QW-1:0] qn;
  logic          is_q, is_p, wr_q, rd_q;
  assign qoff = addr - AW'('h2000);
  assign is_q = addr >= AW'('h2000) && addr[3:0] == 4'hC && (qoff >> 4) < AW'(NQ);
  assign qn   = QW'(qoff >> 4);
  assign wr_q = req & we & is_q;
  assign rd_q = req & ~we & is_q;
  assign poff = addr - AW'('h90);
  assign is_p = addr >= AW'('h90) && addr < AW'('h90 + 4*NPW) && addr[1:0] == 2'b00;

  logic [31:0] paddr, off, slot, amask, gidx;
  logic [5:0]  sh, clog;
  logic        cnt_ok, in_ok, push_ok, push_bad, q_empty, pop, cmp_set;
  logic [IW-1:0] idx;
  assign paddr  = {wdata[31:5], 5'b0};
  assign off    = paddr - rbase;
  assign sh     = 6'(rsz) + 6'd5;
  assign clog   = 6'(rcnt) + 6'd5;
  assign slot   = off >> sh;
  assign amask  = ~(32'hFFFF_FFFF << sh);
  assign cnt_ok = (clog >= 6'd32) || (slot < (32'd1 << clog));
  assign gidx   = 32'(rfirst) + slot;
  assign in_ok  = paddr >= rbase && (off & amask) == 32'd0 && cnt_ok && gidx < 32'(ND);
  assign idx    = gidx[IW-1:0];
  assign push_ok  = wr_q & in_ok;
  assign push_bad = wr_q & ~in_ok;
  assign q_empty  = cnt[qn] == '0;
  assign pop      = rd_q & ~q_empty;
  assign cmp_set  = push_ok & q_empty & CQ_MASK[qn];

  logic [NPW*32-1:0] pvec;
  always_comb begin
    pvec = '0;
    for (int q = 0; q < NQ; q++) pvec[q] = cnt[q] != '0;
  end

  logic [31:0] rd_nx;
  always_comb begin
    rd_nx = 32'd0;
    if (is_q)                          rd_nx = q_empty ? 32'd0 : val[head[qn]];
    else if (is_p)                     rd_nx = pvec[32*(poff >> 2) +: 32];
    else case (addr)
      AW'('h28):   rd_nx = {29'd0, st_cmp, 1'b0, st_err};
      AW'('h2C):   rd_nx = {29'd0, en_cmp, 2'b0};
      AW'('h80):   rd_nx = lbase;
      AW'('h84):   rd_nx = lsize;
      AW'('h1000): rd_nx = rbase;
      AW'('h1004): rd_nx = {rfirst, 4'd0, rsz, 3'd0, rcnt};
      default:     rd_nx = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      val[idx] <= wdata;
      if (!q_empty) nxt[tail[qn]] <= idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        head[q] <= '0; tail[q] <= '0; cnt[q] <= '0;
      end
      rbase <= '0; lbase <= '0; lsize <= '0;
      rfirst <= '0; rsz <= '0; rcnt <= '0;
      st_err <= 1'b0; st_cmp <= 1'b0; en_cmp <= 1'b0;
      rdata <= '0;
    end else begin
      if (req && !we) rdata <= rd_nx;
      if (push_ok) begin
        tail[qn] <= idx;
        if (q_empty) head[qn] <= idx;
        cnt[qn] <= cnt[qn] + 1'b1;
      end else if (pop) begin
        head[qn] <= nxt[head[qn]];
        cnt[qn] <= cnt[qn] - 1'b1;
      end
      if (req && we) case (addr)
        AW'('h2C):   if (wdata[2]) en_cmp <= 1'b1;
        AW'('h30):   if (wdata[2]) en_cmp <= 1'b0;
        AW'('h80):   lbase <= wdata;
        AW'('h84):   lsize <= wdata;
        AW'('h1000): rbase <= wdata;
        AW'('h1004): begin rfirst <= wdata[31:16]; rsz <= wdata[11:8]; rcnt <= wdata[4:0]; end
        default: ;
      endcase
      st_err <= (st_err & ~(req & we & addr == AW'('h28) & wdata[0])) | push_bad;
      st_cmp <= (st_cmp & ~(req & we & addr == AW'('h28) & wdata[2])) | cmp_set;
    end
  end

  assign irq = st_cmp & en_cmp;

  logic [NQ-1:0] pend;
  assign pend = pvec[NQ-1:0];

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && q_empty) |=> (rdata == 32'd0 && $stable(pend))); // R3
  AST_PUSH_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> pend[$past(qn)]); // R2
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    push_bad |=> ($stable(pend) && st_err)); // R6
  AST_LAST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt[qn] == CW'(1)) |=> !pend[$past(qn)]); // R4
  AST_CMP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_set |=> st_cmp); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> en_cmp); // R8
endmodule

// File: tb/desc_queue_mgr_tb_top.sv
module desc_queue_mgr_tb_top;
  localparam int NQ = 40;
  localparam int ND = 32;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  desc_queue_mgr #(.NQ(NQ), .ND(ND), .AW(16), .CQ_MASK(40'hFF_0000_0000)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [15:0] qa(int q);
    return 16'(16'h200C + 16*q);
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] v);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; v = rdata;
  endtask

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %08h expected %08h", r, got, exp);
    end
  endtask

  task automatic rchk(string r, logic [15:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(r, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rchk("R1", 16'h90, 0); rchk("R1", 16'h94, 0); rchk("R1", 16'h28, 0);
    chk("R1", {31'd0, irq}, 0);
    // R9 link memory registers
    wr(16'h80, 32'h1234_5600); wr(16'h84, 32'h200);
    rchk("R9", 16'h80, 32'h1234_5600); rchk("R9", 16'h84, 32'h200);
    // R5 region: 32-byte descriptors, 32 of them, first index 0
    wr(16'h1000, BASE); wr(16'h1004, 32'h0);
    rchk("R5", 16'h1000, BASE);
    // R4 sweep over every queue
    for (int q = 0; q < NQ; q++) begin
      d = BASE + 32'((q % 32) * 32) + 32'(q % 32);
      wr(qa(q), d);
      rchk("R4", 16'h90, q < 32 ? (32'd1 << q) : 32'd0);
      rchk("R4", 16'h94, q >= 32 ? (32'd1 << (q - 32)) : 32'd0);
      rchk("R2", qa(q), d);
      rchk("R4", 16'h90, 0); rchk("R4", 16'h94, 0);
    end
    rchk("R7", 16'h28, 32'h4);
    chk("R7", {31'd0, irq}, 0);
    wr(16'h28, 32'hFFFF_FFFF);
    rchk("R8", 16'h28, 0);
    // R2 FIFO order with hints
    begin
      int ids [5] = '{3, 9, 1, 20, 31};
      for (int k = 0; k < 5; k++) wr(qa(7), BASE + 32'(ids[k] * 32) + 32'(k + 2));
      rchk("R4", 16'h90, 32'd1 << 7);
      for (int k = 0; k < 5; k++) rchk("R2", qa(7), BASE + 32'(ids[k] * 32) + 32'(k + 2));
    end
    rchk("R3", qa(7), 0);
    rchk("R3", 16'h90, 0);
    // R10 interleaved queues
    wr(qa(2), BASE + 32'h020); wr(qa(37), BASE + 32'h040);
    wr(qa(2), BASE + 32'h060); wr(qa(37), BASE + 32'h080);
    rchk("R10", qa(37), BASE + 32'h040); rchk("R10", qa(2), BASE + 32'h020);
    rchk("R10", qa(2), BASE + 32'h060);  rchk("R10", qa(37), BASE + 32'h080);
    wr(16'h28, 32'hFFFF_FFFF);
    // R6 rejections
    wr(qa(3), 32'h7FFF_FFE0);
    rchk("R6", 16'h28, 32'h1); rchk("R6", qa(3), 0);
    wr(16'h28, 32'h1);
    wr(qa(3), BASE + 32'h400);
    rchk("R6", 16'h28, 32'h1); rchk("R6", 16'h90, 0);
    wr(16'h28, 32'h1);
    wr(16'h1004, 32'h100);
    wr(qa(3), BASE + 32'h20);
    rchk("R6", 16'h28, 32'h1); rchk("R6", 16'h90, 0);
    wr(16'h28, 32'h1);
    wr(qa(3), BASE + 32'h40 + 32'h3);
    rchk("R6", 16'h28, 0); rchk("R5", qa(3), BASE + 32'h43);
    wr(16'h1004, 32'h001E_0000);
    rchk("R5", 16'h1004, 32'h001E_0000);
    wr(qa(3), BASE + 32'h40);
    rchk("R6", 16'h28, 32'h1); rchk("R6", qa(3), 0);
    wr(16'h28, 32'h1);
    wr(qa(3), BASE + 32'h20);
    rchk("R5", 16'h28, 0); rchk("R5", qa(3), BASE + 32'h20);
    // R7/R8 completion interrupt
    wr(16'h1004, 32'h0);
    wr(16'h2C, 32'h4);
    rchk("R8", 16'h2C, 32'h4);
    wr(qa(33), BASE + 32'h100);
    chk("R7", {31'd0, irq}, 1); rchk("R7", 16'h28, 32'h4);
    wr(qa(33), BASE + 32'h120);
    wr(16'h28, 32'h4);
    chk("R8", {31'd0, irq}, 0);
    wr(qa(33), BASE + 32'h140);
    chk("R7", {31'd0, irq}, 0); rchk("R7", 16'h28, 0);
    rchk("R2", qa(33), BASE + 32'h100); rchk("R2", qa(33), BASE + 32'h120);
    rchk("R2", qa(33), BASE + 32'h140);
    wr(qa(5), BASE + 32'h160);
    chk("R7", {31'd0, irq}, 0); rchk("R7", 16'h28, 0);
    rchk("R2", qa(5), BASE + 32'h160);
    wr(16'h30, 32'h4);
    rchk("R8", 16'h2C, 0);
    wr(qa(34), BASE + 32'h180);
    chk("R8", {31'd0, irq}, 0); rchk("R7", 16'h28, 32'h4);
    rchk("R2", qa(34), BASE + 32'h180);
    rchk("R4", 16'h94, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule